// File: doc/BRIEF.md
# Mezzanine Slot Access Sequencer

This block sits between a host-side local bus and four plug-in module sites. The host issues one request at a time: a byte offset, a write flag, 16-bit write data and two byte enables. The block decodes the offset into a target: one of the module sites together with one of that site's four address spaces (register I/O, identification, interrupt acknowledge, memory), or one of three local control registers, or nothing at all. A site access drives a one-hot space select to the chosen site and holds it until the site answers. The block then completes the host cycle with the site's read data.

Sites that never answer are handled by an optional bus-error timer. While auto-acknowledge is enabled, the timer ends an unanswered site access after a fixed time. It returns all ones and pulses a timeout event for a neighbouring status block. Offsets that decode to no site are rejected at once with an error flag. The timer never handles them. A map-select input chooses between a large memory layout (8 MB per site) and a compact one (2 KB per site). The register spaces and the control registers sit at the same offsets in both layouts.

Top module: `mezz_slot_seq`

## Requirements
- R1: After reset, req_ready is 1, and slot_sel, rsp_valid, ctrl_stb, slot_ackd and timeout_evt are all 0.
- R2: An offset of 0x1000*(s+1) + 0x100*k + x with s in 0..3, k in 0..2 and x < 0x100 selects site s. The space code is k (0 = I/O, 1 = ID, 2 = interrupt; memory has code 3). The select bit is slot_sel[4*s + code]. It shows in the cycle after acceptance, with slot_addr = x. A k of 3 or more is unmapped.
- R3: With map_small = 0, an offset of 0x0100_0000 + s*0x0080_0000 + x with x < 0x80_0000 selects the memory space of site s, with slot_addr = x. The range 0x5000 to 0x6FFF is unmapped in this layout.
- R4: With map_small = 1, an offset of 0x5000 + s*0x800 + x with x < 0x800 selects the memory space of site s, with slot_addr = x. Offsets at 0x0100_0000 and above are unmapped in this layout.
- R5: For an interrupt-space access, slot_irq_line equals bit 1 of the offset (0 = line 0, 1 = line 1).
- R6: An offset in 0x500 to 0x7FF raises ctrl_stb for one cycle, in the cycle after acceptance, with ctrl_idx = (offset >> 8) - 5. One cycle later the response carries the ctrl_rdata seen during the strobe.
- R7: An unmapped offset completes in the cycle after acceptance with rsp_err = 1 and rsp_rdata = 0xFFFF. It selects no site and raises no timeout event, whatever auto_ack_en is.
- R8: The cycle after the selected site raises slot_ack, the block gives rsp_valid with that site's slot_rdata and rsp_err = rsp_timeout = 0. The same cycle it pulses slot_ackd for that site and clears slot_sel. While the site is selected, bus_we, bus_wdata and bus_be carry the request. Acknowledges from other sites are ignored.
- R9: With auto_ack_en = 1, a site access that gets no acknowledge is ended by the block. rsp_valid, rsp_timeout and timeout_evt are high in the cycle after the TMO_CYC-th clock edge following acceptance (103 by default), with rsp_rdata = 0xFFFF and slot_ackd = 0.
- R10: With auto_ack_en = 0, a site access waits for its acknowledge with no time limit.
- R11: req_ready is 0 from the cycle after a site or control access is accepted until the cycle its response is given. A request presented meanwhile is ignored and gets no response.
- R12: An acknowledge sampled on the same edge at which the timer would expire wins: the response is a normal acknowledged completion with no timeout event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| map_small | input | 1 | 1 selects the compact memory layout |
| auto_ack_en | input | 1 | Enables the bus-error timer |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte offset of the request |
| req_we | input | 1 | 1 = write |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| rsp_valid | output | 1 | One-cycle completion |
| rsp_rdata | output | DATA_W | Read data of the completion |
| rsp_err | output | 1 | Completion of an unmapped offset |
| rsp_timeout | output | 1 | Completion made by the timer |
| ctrl_stb | output | 1 | Local control register access strobe |
| ctrl_idx | output | 2 | Control register index |
| ctrl_rdata | input | DATA_W | Read data of the addressed control register |
| slot_sel | output | NSLOT*4 | One-hot select, bit 4*site + space |
| slot_addr | output | OFF_W | Offset within the selected space |
| slot_irq_line | output | 1 | Interrupt line of an acknowledge cycle |
| bus_we | output | 1 | Write flag towards sites and control |
| bus_wdata | output | DATA_W | Write data towards sites and control |
| bus_be | output | DATA_W/8 | Byte enables towards sites and control |
| slot_ack | input | NSLOT | Per-site acknowledge |
| slot_rdata | input | NSLOT*DATA_W | Per-site read data |
| slot_ackd | output | NSLOT | One-cycle per-site "acknowledged by module" pulse |
| timeout_evt | output | 1 | One-cycle bus-error timeout event |

## Verification
The hardest case to reach is the race between a site acknowledge and the timer expiry on the very same edge. Only an acknowledge placed at exactly the right cycle count exercises the priority. The bench's site model waits a programmable number of select cycles before it answers. Runs with that delay set to exactly the timeout count and one beyond it sit on either side of the boundary. An unanswered access with the timer disabled is driven while further requests are presented to the busy block. This shows both the unlimited wait and the ignored requests.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [1:0] {SP_IO = 2'd0, SP_ID = 2'd1, SP_INT = 2'd2, SP_MEM = 2'd3} space_e;
  typedef enum logic [1:0] {K_NONE = 2'd0, K_SLOT = 2'd1, K_CTRL = 2'd2} kind_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_WAIT = 2'd1, ST_CTRL = 2'd2} st_e;
endpackage

// File: rtl/mss_decode.sv
module mss_decode
  import mss_pkg::*;
#(
  parameter int          ADDR_W    = 26,
  parameter int          NSLOT     = 4,
  parameter int          OFF_W     = 23,
  parameter int          NCTRL     = 3,
  parameter int          SLOT_W    = $clog2(NSLOT),
  parameter int          CIDX_W    = $clog2(NCTRL),
  parameter logic [31:0] CTRL_BASE = 32'h0000_0500,
  parameter int          CTRL_LOG  = 8,
  parameter logic [31:0] REG_BASE  = 32'h0000_1000,
  parameter int          REG_LOG   = 12,
  parameter int          SPC_LOG   = 8,
  parameter logic [31:0] MEMF_BASE = 32'h0100_0000,
  parameter int          MEMF_LOG  = 23,
  parameter logic [31:0] MEMR_BASE = 32'h0000_5000,
  parameter int          MEMR_LOG  = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              map_small,
  output kind_e             kind,
  output logic [SLOT_W-1:0] slot,
  output space_e            space,
  output logic [OFF_W-1:0]  off,
  output logic [CIDX_W-1:0] cidx
);
  localparam int SUB_W = REG_LOG - SPC_LOG;
  localparam logic [ADDR_W-1:0] CB = CTRL_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] RB = REG_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] FB = MEMF_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] QB = MEMR_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W:0] CSPAN = (ADDR_W+1)'(NCTRL) << CTRL_LOG;
  localparam logic [ADDR_W:0] RSPAN = (ADDR_W+1)'(NSLOT) << REG_LOG;
  localparam logic [ADDR_W:0] FSPAN = (ADDR_W+1)'(NSLOT) << MEMF_LOG;
  localparam logic [ADDR_W:0] QSPAN = (ADDR_W+1)'(NSLOT) << MEMR_LOG;
  localparam logic [ADDR_W-1:0] SPC_MASK = (ADDR_W'(1) << SPC_LOG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] F_MASK   = (ADDR_W'(1) << MEMF_LOG) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] Q_MASK   = (ADDR_W'(1) << MEMR_LOG) - ADDR_W'(1);

  logic [ADDR_W-1:0] c_rel, r_rel, f_rel, q_rel;
  logic [SUB_W-1:0]  r_sub;
  logic              c_hit, r_hit, f_hit, q_hit;

  always_comb begin
    c_rel = addr - CB;
    r_rel = addr - RB;
    f_rel = addr - FB;
    q_rel = addr - QB;
    r_sub = r_rel[REG_LOG-1:SPC_LOG];
    c_hit = (addr >= CB) && ({1'b0, c_rel} < CSPAN);
    r_hit = (addr >= RB) && ({1'b0, r_rel} < RSPAN) && (r_sub < SUB_W'(3));
    f_hit = !map_small && (addr >= FB) && ({1'b0, f_rel} < FSPAN);
    q_hit =  map_small && (addr >= QB) && ({1'b0, q_rel} < QSPAN);

    kind  = K_NONE;
    slot  = '0;
    space = SP_IO;
    off   = '0;
    cidx  = '0;
    if (c_hit) begin
      kind = K_CTRL;
      cidx = CIDX_W'(c_rel >> CTRL_LOG);
    end else if (r_hit) begin
      kind  = K_SLOT;
      slot  = SLOT_W'(r_rel >> REG_LOG);
      space = space_e'(r_sub[1:0]);
      off   = OFF_W'(r_rel & SPC_MASK);
    end else if (f_hit) begin
      kind  = K_SLOT;
      slot  = SLOT_W'(f_rel >> MEMF_LOG);
      space = SP_MEM;
      off   = OFF_W'(f_rel & F_MASK);
    end else if (q_hit) begin
      kind  = K_SLOT;
      slot  = SLOT_W'(q_rel >> MEMR_LOG);
      space = SP_MEM;
      off   = OFF_W'(q_rel & Q_MASK);
    end
  end
endmodule

// File: rtl/mss_ack_timer.sv
module mss_ack_timer #(
  parameter int TMO_CYC = 103
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYC + 1);
  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)        cnt <= '0;
    else if (run && !expire) cnt <= cnt + 1'b1;
  end

  // R9: the count never passes the expiry point
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TMO_CYC));
endmodule

// File: rtl/mss_rdata_mux.sv
module mss_rdata_mux #(
  parameter int NSLOT  = 4,
  parameter int DATA_W = 16,
  parameter int SLOT_W = $clog2(NSLOT)
) (
  input  logic [NSLOT*DATA_W-1:0] bus,
  input  logic [SLOT_W-1:0]       sel,
  output logic [DATA_W-1:0]       q
);
  logic [DATA_W-1:0] lane [NSLOT];
  for (genvar g = 0; g < NSLOT; g++) begin : g_lane
    assign lane[g] = bus[g*DATA_W +: DATA_W];
  end
  assign q = lane[sel];
endmodule

// File: rtl/mezz_slot_seq.sv
module mezz_slot_seq
  import mss_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int DATA_W  = 16,
  parameter int NSLOT   = 4,
  parameter int OFF_W   = 23,
  parameter int NCTRL   = 3,
  parameter int CLK_KHZ = 32000,
  parameter int TMO_NS  = 3200
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      map_small,
  input  logic                      auto_ack_en,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_we,
  input  logic [DATA_W-1:0]         req_wdata,
  input  logic [DATA_W/8-1:0]       req_be,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  output logic                      rsp_err,
  output logic                      rsp_timeout,
  output logic                      ctrl_stb,
  output logic [$clog2(NCTRL)-1:0]  ctrl_idx,
  input  logic [DATA_W-1:0]         ctrl_rdata,
  output logic [NSLOT*4-1:0]        slot_sel,
  output logic [OFF_W-1:0]          slot_addr,
  output logic                      slot_irq_line,
  output logic                      bus_we,
  output logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W/8-1:0]       bus_be,
  input  logic [NSLOT-1:0]          slot_ack,
  input  logic [NSLOT*DATA_W-1:0]   slot_rdata,
  output logic [NSLOT-1:0]          slot_ackd,
  output logic                      timeout_evt
);
  localparam int NSPACE  = 4;
  localparam int SEL_W   = NSLOT * NSPACE;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int CIDX_W  = $clog2(NCTRL);
  localparam int TMO_RAW = (CLK_KHZ * TMO_NS + 999_999) / 1_000_000;
  localparam int TMO_CYC = (TMO_RAW < 1) ? 1 : TMO_RAW;

  st_e               state;
  kind_e             d_kind;
  logic [SLOT_W-1:0] d_slot;
  space_e            d_space;
  logic [OFF_W-1:0]  d_off;
  logic [CIDX_W-1:0] d_cidx;
  logic [SLOT_W-1:0] cur_slot;
  logic [DATA_W-1:0] mux_q;
  logic              cur_ack, expire;

  mss_decode #(
    .ADDR_W(ADDR_W), .NSLOT(NSLOT), .OFF_W(OFF_W), .NCTRL(NCTRL),
    .SLOT_W(SLOT_W), .CIDX_W(CIDX_W)
  ) u_dec (
    .addr(req_addr), .map_small(map_small), .kind(d_kind), .slot(d_slot),
    .space(d_space), .off(d_off), .cidx(d_cidx)
  );

  mss_ack_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk(clk), .rst(rst),
    .run(state == ST_WAIT && auto_ack_en),
    .clear(state != ST_WAIT),
    .expire(expire)
  );

  mss_rdata_mux #(.NSLOT(NSLOT), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_mux (
    .bus(slot_rdata), .sel(cur_slot), .q(mux_q)
  );

  assign cur_ack   = slot_ack[cur_slot];
  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_err       <= 1'b0;
      rsp_timeout   <= 1'b0;
      ctrl_stb      <= 1'b0;
      ctrl_idx      <= '0;
      slot_sel      <= '0;
      slot_addr     <= '0;
      slot_irq_line <= 1'b0;
      bus_we        <= 1'b0;
      bus_wdata     <= '0;
      bus_be        <= '0;
      slot_ackd     <= '0;
      timeout_evt   <= 1'b0;
      cur_slot      <= '0;
    end else begin
      rsp_valid   <= 1'b0;
      ctrl_stb    <= 1'b0;
      slot_ackd   <= '0;
      timeout_evt <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          bus_we    <= req_we;
          bus_wdata <= req_wdata;
          bus_be    <= req_be;
          case (d_kind)
            K_SLOT: begin
              slot_sel      <= SEL_W'(1) << (int'(d_slot) * NSPACE + int'(d_space));
              cur_slot      <= d_slot;
              slot_addr     <= d_off;
              slot_irq_line <= (d_space == SP_INT) && req_addr[1];
              state         <= ST_WAIT;
            end
            K_CTRL: begin
              ctrl_stb <= 1'b1;
              ctrl_idx <= d_cidx;
              state    <= ST_CTRL;
            end
            default: begin
              rsp_valid   <= 1'b1;
              rsp_err     <= 1'b1;
              rsp_timeout <= 1'b0;
              rsp_rdata   <= '1;
            end
          endcase
        end
        ST_WAIT: begin
          if (cur_ack) begin
            rsp_valid   <= 1'b1;
            rsp_rdata   <= mux_q;
            rsp_err     <= 1'b0;
            rsp_timeout <= 1'b0;
            slot_ackd   <= NSLOT'(1) << cur_slot;
            slot_sel    <= '0;
            state       <= ST_IDLE;
          end else if (expire) begin
            rsp_valid   <= 1'b1;
            rsp_rdata   <= '1;
            rsp_err     <= 1'b0;
            rsp_timeout <= 1'b1;
            timeout_evt <= 1'b1;
            slot_sel    <= '0;
            state       <= ST_IDLE;
          end
        end
        ST_CTRL: begin
          rsp_valid   <= 1'b1;
          rsp_rdata   <= ctrl_rdata;
          rsp_err     <= 1'b0;
          rsp_timeout <= 1'b0;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: at most one site space is selected at any time
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_sel));
  // R11: an accepted site or control access makes the block busy
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && d_kind != K_NONE) |=> !req_ready);
  // R9: a timeout event needs the timer enabled in the cycle before
  p_tmo_needs_auto_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> $past(auto_ack_en));
  // R12: timer completion and module acknowledge never coincide
  p_ackd_excl_r12: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> (slot_ackd == '0));
  // R7: only a site access in progress can time out
  p_tmo_from_wait_r7: assert property (@(posedge clk) disable iff (rst)
    timeout_evt |-> $past(|slot_sel));
  // R8: no site remains selected once a response is given
  p_sel_clear_on_rsp_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (slot_sel == '0));
endmodule

// File: tb/tb_mezz_slot_seq.sv
module tb_mezz_slot_seq;
  localparam int TMO = 103;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        map_small = 1'b0, auto_ack_en = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [25:0] req_addr = '0;
  logic [15:0] req_wdata = '0, ctrl_rdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid, rsp_err, rsp_timeout, ctrl_stb;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [1:0]  ctrl_idx, bus_be;
  logic [15:0] slot_sel;
  logic [22:0] slot_addr;
  logic        slot_irq_line, bus_we, timeout_evt;
  logic [3:0]  slot_ack, slot_ackd, ack_m = '0, force_ack = '0;
  logic [63:0] slot_rdata = '0;

  assign slot_ack = ack_m | force_ack;

  mezz_slot_seq dut (
    .clk(clk), .rst(rst), .map_small(map_small), .auto_ack_en(auto_ack_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_we(req_we), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_timeout(rsp_timeout), .ctrl_stb(ctrl_stb), .ctrl_idx(ctrl_idx),
    .ctrl_rdata(ctrl_rdata), .slot_sel(slot_sel), .slot_addr(slot_addr),
    .slot_irq_line(slot_irq_line), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .slot_ack(slot_ack), .slot_rdata(slot_rdata),
    .slot_ackd(slot_ackd), .timeout_evt(timeout_evt)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, acc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int s, input int sp, input logic [7:0] o);
    return {4'hA, 2'(s), 2'(sp), o};
  endfunction

  // Site model: answers after slot_dly[s] cycles of select
  bit   slot_en [4];
  int   slot_dly[4];
  int   m_cnt   [4];
  logic [3:0] m_ss;
  int   m_sp;
  always @(negedge clk) begin
    for (int s = 0; s < 4; s++) begin
      m_ss = slot_sel[s*4 +: 4];
      m_sp = m_ss[1] ? 1 : m_ss[2] ? 2 : m_ss[3] ? 3 : 0;
      if (|m_ss && slot_en[s]) begin
        m_cnt[s]++;
        ack_m[s] <= (m_cnt[s] == slot_dly[s]);
        slot_rdata[s*16 +: 16] <= pat(s, m_sp, slot_addr[7:0]);
      end else begin
        m_cnt[s] = 0;
        ack_m[s] <= 1'b0;
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic [15:0] rdata; bit err; bit tmo; logic [3:0] ackd; int lat; string tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q.size() == 0) chk(1'b0, "R11", "unexpected response", 1, 0);
      else begin
        e = q.pop_front();
        chk(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
        chk(rsp_err == e.err, e.tag, "err", rsp_err, e.err);
        chk(rsp_timeout == e.tmo && timeout_evt == e.tmo, e.tag, "timeout",
            {rsp_timeout, timeout_evt}, {e.tmo, e.tmo});
        chk(slot_ackd == e.ackd, e.tag, "slot_ackd", slot_ackd, e.ackd);
        chk(cyc - acc == e.lat, e.tag, "latency", cyc - acc, e.lat);
      end
    end
  end

  task automatic issue(input logic [25:0] a, input bit we, input logic [15:0] wd,
                       input logic [15:0] er, input bit eerr, input bit etmo,
                       input logic [3:0] eackd, input int elat, input int esel,
                       input logic [22:0] eoff, input bit eirq, input int ectrl,
                       input string tag);
    exp_t x;
    x.rdata = er; x.err = eerr; x.tmo = etmo; x.ackd = eackd; x.lat = elat; x.tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(x);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = wd; req_be = 2'b11;
    @(posedge clk);
    #1 acc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    if (esel >= 0) begin
      chk(slot_sel == (16'(1) << esel), tag, "select", slot_sel, 16'(1) << esel);
      chk(slot_addr == eoff, tag, "slot_addr", slot_addr, eoff);
      chk(slot_irq_line == eirq, tag, "irq line", slot_irq_line, eirq);
      chk(bus_we == we && bus_be == 2'b11 && (!we || bus_wdata == wd), tag, "bus write",
          {bus_we, bus_wdata}, {we, wd});
    end else begin
      chk(slot_sel == 16'h0, tag, "no select", slot_sel, 0);
    end
    if (ectrl >= 0) chk(ctrl_stb && ctrl_idx == 2'(ectrl), tag, "ctrl strobe",
                        {ctrl_stb, ctrl_idx}, {1'b1, 2'(ectrl)});
    else chk(!ctrl_stb, tag, "no ctrl strobe", ctrl_stb, 0);
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin slot_en[s] = 1'b1; slot_dly[s] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: idle state after reset
    chk(req_ready && slot_sel == 0 && !rsp_valid && !ctrl_stb && slot_ackd == 0 && !timeout_evt,
        "R1", "reset state", {req_ready, slot_sel, rsp_valid}, {1'b1, 16'h0, 1'b0});

    // R2: every site, every register space
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 3; k++) begin
        slot_dly[s] = s + 1;
        issue(26'(32'h1000 * (s + 1) + 32'h100 * k + 32'h20), 1'b0, 16'h0,
              pat(s, k, 8'h20), 0, 0, 4'(1 << s), s + 1, s*4 + k, 23'h20, 1'b0, -1, "R2");
      end
    end
    // R2: sub-space code 3 inside a site block is unmapped
    issue(26'h1300, 1'b0, 16'h0, 16'hFFFF, 1, 0, 4'h0, 0, -1, 23'h0, 1'b0, -1, "R2");

    // R5: interrupt line follows address bit 1
    slot_dly[2] = 1;
    issue(26'h3200, 1'b0, 16'h0, pat(2, 2, 8'h00), 0, 0, 4'b0100, 1, 10, 23'h0, 1'b0, -1, "R5");
    issue(26'h3202, 1'b0, 16'h0, pat(2, 2, 8'h02), 0, 0, 4'b0100, 1, 10, 23'h2, 1'b1, -1, "R5");

    // R3: full memory layout
    slot_dly[2] = 2;
    issue(26'h0100_0000 + 26'h0100_0000 + 26'h1234, 1'b0, 16'h0, pat(2, 3, 8'h34), 0, 0,
          4'b0100, 2, 11, 23'h1234, 1'b0, -1, "R3");
    issue(26'h0000_5800, 1'b0, 16'h0, 16'hFFFF, 1, 0, 4'h0, 0, -1, 23'h0, 1'b0, -1, "R3");

    // R4: compact memory layout
    map_small = 1'b1;
    slot_dly[1] = 3;
    issue(26'h5800 + 26'h7F, 1'b0, 16'h0, pat(1, 3, 8'h7F), 0, 0, 4'b0010, 3, 7,
          23'h7F, 1'b0, -1, "R4");
    issue(26'h0100_0000, 1'b0, 16'h0, 16'hFFFF, 1, 0, 4'h0, 0, -1, 23'h0, 1'b0, -1, "R4");
    map_small = 1'b0;

    // R6: control registers
    ctrl_rdata = 16'h1111;
    issue(26'h500, 1'b0, 16'h0, 16'h1111, 0, 0, 4'h0, 1, -1, 23'h0, 1'b0, 0, "R6");
    ctrl_rdata = 16'h2222;
    issue(26'h6FE, 1'b0, 16'h0, 16'h2222, 0, 0, 4'h0, 1, -1, 23'h0, 1'b0, 1, "R6");
    ctrl_rdata = 16'h3333;
    issue(26'h7FF, 1'b1, 16'h00C3, 16'h3333, 0, 0, 4'h0, 1, -1, 23'h0, 1'b0, 2, "R6");

    // R7: unmapped offsets, timer enabled, no timeout event
    auto_ack_en = 1'b1;
    issue(26'h800, 1'b0, 16'h0, 16'hFFFF, 1, 0, 4'h0, 0, -1, 23'h0, 1'b0, -1, "R7");
    issue(26'h0, 1'b0, 16'h0, 16'hFFFF, 1, 0, 4'h0, 0, -1, 23'h0, 1'b0, -1, "R7");

    // R8: write with other site's acknowledge ignored
    slot_dly[2] = 6;
    fork
      issue(26'h3010, 1'b1, 16'hBEEF, pat(2, 0, 8'h10), 0, 0, 4'b0100, 6, 8, 23'h10, 1'b0, -1, "R8");
      begin
        repeat (2) @(negedge clk);
        force_ack = 4'b1011;
        repeat (3) @(negedge clk);
        force_ack = 4'b0000;
      end
    join

    // R9: timeout on a silent site (read and write)
    slot_en[3] = 1'b0;
    issue(26'h4010, 1'b0, 16'h0, 16'hFFFF, 0, 1, 4'h0, TMO, 12, 23'h10, 1'b0, -1, "R9");
    issue(26'h4110, 1'b1, 16'h55AA, 16'hFFFF, 0, 1, 4'h0, TMO, 13, 23'h10, 1'b0, -1, "R9");
    slot_en[3] = 1'b1;

    // R12: acknowledge on the expiry edge wins; one cycle later it loses
    slot_dly[0] = TMO;
    issue(26'h1040, 1'b0, 16'h0, pat(0, 0, 8'h40), 0, 0, 4'b0001, TMO, 0, 23'h40, 1'b0, -1, "R12");
    slot_dly[0] = TMO + 1;
    issue(26'h1040, 1'b0, 16'h0, 16'hFFFF, 0, 1, 4'h0, TMO, 0, 23'h40, 1'b0, -1, "R12");

    // R10 and R11: timer off, long wait, requests while busy are ignored
    auto_ack_en = 1'b0;
    slot_dly[1] = 300;
    fork
      issue(26'h2100, 1'b0, 16'h0, pat(1, 1, 8'h00), 0, 0, 4'b0010, 300, 5, 23'h0, 1'b0, -1, "R10");
      begin
        repeat (6) @(negedge clk);
        chk(req_ready == 1'b0, "R11", "ready while busy", req_ready, 0);
        req_valid = 1'b1; req_addr = 26'h0500;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        chk(slot_sel == 16'h0020 && !ctrl_stb, "R11", "busy request ignored", slot_sel, 16'h0020);
      end
    join
    repeat (10) @(negedge clk);
    chk(q.size() == 0 && req_ready, "R11", "idle after completion", req_ready, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule